// File: doc/BRIEF.md
# Serial Command Receiver with Resynchronising Deadline

This block sits on the instrument side of a synchronous serial command link. A controller sends a continuous serial clock, a data line and a frame-sync line. The receiver samples one data bit on each rising serial-clock edge while frame-sync is low, most significant bit first. A frame-sync high at a rising edge marks the boundary between two units. It assembles either three 8-bit units (byte mode) or two 16-bit units (word mode: parameter word, then command word) into one command and presents it for one system-clock cycle.

A deadline protects the framing. It starts on the first data bit of a command and lasts 15 µs in byte mode or 18 µs in word mode, counted in system-clock cycles from the clock frequency parameter. If the command is not complete by then, or a unit boundary shows up at the wrong bit count, the partial command is dropped. A one-cycle abort event is raised, and the receiver waits for a fresh first bit. Between commands the controller either stops the serial clock or holds frame-sync high.

The result leaves as a valid strobe with data and no ready. A serial link cannot be held off, so there is no back-pressure. The consumer must take the data in the strobe cycle. The data lines keep their value afterwards, so a late reader still finds the last command. The serial inputs are asynchronous and pass through two-flop synchronizers. The design then works on sampled rising edges of the serial clock.

Top module: `cmd_link_rx`

## Requirements
- R1: In byte mode (MODE=0), three 8-bit units are assembled MSB first into a 24-bit `cmd_data_o`, first unit in bits 23:16, last unit in bits 7:0.
- R2: In word mode (MODE=1), two 16-bit units are assembled into a 32-bit `cmd_data_o`, parameter word in bits 31:16 and command word in bits 15:0.
- R3: A data bit is a rising serial-clock edge with frame-sync low. A rising edge with frame-sync high is a unit boundary and carries no data. A boundary is required between consecutive units of one command.
- R4: The deadline is CLK_MHZ×15000/1000 cycles (byte) or CLK_MHZ×18000/1000 cycles (word), started by the first data bit. A command whose last bit is detected within that limit is accepted, even if it arrives later than usual.
- R5: When the deadline passes before the last bit, the partial command is discarded. `timeout_evt_o` pulses for one cycle, no `cmd_valid_o` is produced, and the next data bit starts a new command.
- R6: A boundary sampled while a unit is partly received (bit count not 0) is a framing error, handled exactly like a deadline expiry.
- R7: A data bit arriving where a boundary is due (after a complete, non-final unit) is a framing error. That bit is dropped, and the following data bit starts a new command.
- R8: Boundaries sampled while no command is in progress are ignored and raise no event.
- R9: `cmd_valid_o` lasts one cycle. `cmd_data_o` changes only together with it, so aborts leave the last command in place.
- R10: During and right after reset, `cmd_valid_o`, `timeout_evt_o` and `cmd_data_o` are zero.
- R11: `cmd_valid_o` and `timeout_evt_o` are never high in the same cycle. A last bit detected in the expiry cycle completes the command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_clk_i | input | 1 | Serial clock from the controller (asynchronous) |
| ser_dat_i | input | 1 | Serial data, sampled on rising serial-clock edges |
| ser_sync_i | input | 1 | Frame-sync, high for one serial clock between units |
| cmd_valid_o | output | 1 | One-cycle strobe: a complete command is on cmd_data_o |
| cmd_data_o | output | 24 (MODE=0) / 32 (MODE=1) | Assembled command, first unit in the top bits |
| timeout_evt_o | output | 1 | One-cycle pulse: partial command dropped (deadline or framing) |

## Verification
A wrong bit or unit counter shows at the ports as a missing or shifted command at the next strobe. A stale boundary flag shows as a spurious abort on the first bit of the second unit. A timer that starts late, or is never cleared, shows one deadline later as an abort where a slow but legal command should pass, or as a missing abort after a stalled one. The bench queues the expected commands and abort counts for each scenario. It compares them as each strobe or pulse appears, and it also confirms that the held data survive every abort.

// File: rtl/clr_pkg.sv
package clr_pkg;

  typedef enum logic {
    CLR_BYTE = 1'b0,
    CLR_WORD = 1'b1
  } clr_mode_e;

  function automatic int unit_bits(input clr_mode_e m);
    return (m == CLR_WORD) ? 16 : 8;
  endfunction

  function automatic int unit_count(input clr_mode_e m);
    return (m == CLR_WORD) ? 2 : 3;
  endfunction

  function automatic int limit_ns(input clr_mode_e m);
    return (m == CLR_WORD) ? 18000 : 15000;
  endfunction

endpackage

// File: rtl/clr_sync2.sv
module clr_sync2 #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1, s2;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        s1 <= 1'b0;
        s2 <= 1'b0;
      end else begin
        s1 <= d_i[i];
        s2 <= s1;
      end
    end
    assign q_o[i] = s2;
  end
endmodule

// File: rtl/clr_deadline.sv
module clr_deadline #(
  parameter int LIMIT = 3000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic clear_i,
  output logic expire_o
);
  localparam int CW = $clog2(LIMIT + 1);

  logic          run_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (start_i) begin
      run_q <= 1'b1;
      cnt_q <= '0;
    end else if (clear_i) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (run_q) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign expire_o = run_q && (cnt_q == CW'(LIMIT - 1));
endmodule

// File: rtl/clr_framer.sv
module clr_framer #(
  parameter int UNIT_W  = 8,
  parameter int N_UNITS = 3,
  parameter int CMD_W   = UNIT_W * N_UNITS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_stb_i,
  input  logic             bit_val_i,
  input  logic             sync_lvl_i,
  input  logic             expire_i,
  output logic             start_o,
  output logic             clear_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             abort_o,
  output logic [CMD_W-1:0] cmd_data_o
);
  localparam int BW = $clog2(UNIT_W);
  localparam int UW = (N_UNITS > 1) ? $clog2(N_UNITS) : 1;

  logic [BW-1:0]    bit_cnt_q;
  logic [UW-1:0]    unit_cnt_q;
  logic [CMD_W-1:0] shreg_q, data_q, shifted;
  logic             busy_q, need_mark_q, done_q, abort_q;
  logic             is_data, is_mark, ferr, accept, unit_end, last, tmo;

  always_comb begin
    is_data  = bit_stb_i && !sync_lvl_i;
    is_mark  = bit_stb_i && sync_lvl_i;
    ferr     = busy_q && ((is_mark && (bit_cnt_q != '0)) || (is_data && need_mark_q));
    accept   = is_data && !ferr;
    unit_end = accept && (bit_cnt_q == BW'(UNIT_W - 1));
    last     = unit_end && (unit_cnt_q == UW'(N_UNITS - 1));
    tmo      = expire_i && busy_q && !last;
    shifted  = busy_q ? {shreg_q[CMD_W-2:0], bit_val_i}
                      : {{(CMD_W-1){1'b0}}, bit_val_i};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bit_cnt_q   <= '0;
      unit_cnt_q  <= '0;
      shreg_q     <= '0;
      data_q      <= '0;
      busy_q      <= 1'b0;
      need_mark_q <= 1'b0;
      done_q      <= 1'b0;
      abort_q     <= 1'b0;
    end else begin
      done_q  <= last;
      abort_q <= ferr || tmo;
      if (last) data_q <= shifted;
      if (ferr || tmo) begin
        busy_q      <= 1'b0;
        need_mark_q <= 1'b0;
        bit_cnt_q   <= '0;
        unit_cnt_q  <= '0;
      end else begin
        if (is_mark) need_mark_q <= 1'b0;
        if (accept) begin
          shreg_q <= shifted;
          busy_q  <= !last;
          if (unit_end) begin
            bit_cnt_q   <= '0;
            need_mark_q <= !last;
            unit_cnt_q  <= last ? '0 : unit_cnt_q + 1'b1;
          end else begin
            bit_cnt_q <= bit_cnt_q + 1'b1;
          end
        end
      end
    end
  end

  assign start_o    = accept && !busy_q;
  assign clear_o    = ferr || tmo || last;
  assign busy_o     = busy_q;
  assign done_o     = done_q;
  assign abort_o    = abort_q;
  assign cmd_data_o = data_q;
endmodule

// File: rtl/cmd_link_rx.sv
module cmd_link_rx
  import clr_pkg::*;
#(
  parameter clr_mode_e MODE    = CLR_BYTE,
  parameter int        CLK_MHZ = 200,
  localparam int       UNIT_W  = unit_bits(MODE),
  localparam int       N_UNITS = unit_count(MODE),
  localparam int       CMD_W   = UNIT_W * N_UNITS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ser_clk_i,
  input  logic             ser_dat_i,
  input  logic             ser_sync_i,
  output logic             cmd_valid_o,
  output logic [CMD_W-1:0] cmd_data_o,
  output logic             timeout_evt_o
);
  localparam int TIMEOUT_CYC = CLK_MHZ * limit_ns(MODE) / 1000;

  logic [2:0] raw_in, syn_in;
  logic       sclk_s, dat_s, fs_s, sclk_q, rise;
  logic       start, clear, expire, rx_busy;

  assign raw_in = {ser_clk_i, ser_dat_i, ser_sync_i};

  clr_sync2 #(.W(3)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d_i  (raw_in),
    .q_o  (syn_in)
  );

  assign {sclk_s, dat_s, fs_s} = syn_in;

  always_ff @(posedge clk) begin
    if (!rst_n) sclk_q <= 1'b0;
    else        sclk_q <= sclk_s;
  end

  assign rise = sclk_s && !sclk_q;

  clr_deadline #(.LIMIT(TIMEOUT_CYC)) u_deadline (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start),
    .clear_i (clear),
    .expire_o(expire)
  );

  clr_framer #(.UNIT_W(UNIT_W), .N_UNITS(N_UNITS), .CMD_W(CMD_W)) u_framer (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_stb_i (rise),
    .bit_val_i (dat_s),
    .sync_lvl_i(fs_s),
    .expire_i  (expire),
    .start_o   (start),
    .clear_o   (clear),
    .busy_o    (rx_busy),
    .done_o    (cmd_valid_o),
    .abort_o   (timeout_evt_o),
    .cmd_data_o(cmd_data_o)
  );
endmodule

// File: rtl/clr_checker.sv
module clr_checker #(
  parameter int TIMEOUT_CYC = 3000,
  parameter int CMD_W       = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic             timeout_evt,
  input logic [CMD_W-1:0] cmd_data,
  input logic             busy
);
  localparam int AW = $clog2(TIMEOUT_CYC + 2);
  logic [AW-1:0] age_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    age_q <= '0;
    else if (busy) age_q <= age_q + 1'b1;
    else           age_q <= '0;
  end

  a_r9_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);

  a_r9_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |-> $stable(cmd_data));

  a_r5_timeout_single: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_evt |=> !timeout_evt);

  a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid && timeout_evt));

  a_r4_deadline_bound: assert property (@(posedge clk) disable iff (!rst_n)
    age_q <= AW'(TIMEOUT_CYC));
endmodule

bind cmd_link_rx clr_checker #(.TIMEOUT_CYC(TIMEOUT_CYC), .CMD_W(CMD_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_valid  (cmd_valid_o),
  .timeout_evt(timeout_evt_o),
  .cmd_data   (cmd_data_o),
  .busy       (rx_busy)
);

// File: tb/cmd_link_rx_tb_top.sv
`timescale 1ns/1ps
module cmd_link_rx_tb_top;
  import clr_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic b_sclk = 0, b_dat = 0, b_fs = 0;
  logic w_sclk = 0, w_dat = 0, w_fs = 0;
  logic        b_valid, b_to, w_valid, w_to;
  logic [23:0] b_data;
  logic [31:0] w_data;

  cmd_link_rx #(.MODE(CLR_BYTE), .CLK_MHZ(200)) dut_i (
    .clk(clk), .rst_n(rst_n), .ser_clk_i(b_sclk), .ser_dat_i(b_dat),
    .ser_sync_i(b_fs), .cmd_valid_o(b_valid), .cmd_data_o(b_data),
    .timeout_evt_o(b_to)
  );

  cmd_link_rx #(.MODE(CLR_WORD), .CLK_MHZ(200)) dut_w_i (
    .clk(clk), .rst_n(rst_n), .ser_clk_i(w_sclk), .ser_dat_i(w_dat),
    .ser_sync_i(w_fs), .cmd_valid_o(w_valid), .cmd_data_o(w_data),
    .timeout_evt_o(w_to)
  );

  int nchk = 0, nfail = 0;
  logic [31:0] exp_b[$], exp_w[$];
  int seen_to_b = 0, seen_to_w = 0, exp_to_b = 0, exp_to_w = 0;
  logic [31:0] last_b = 0, last_w = 0;
  logic prev_bv = 0, prev_wv = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (b_valid) begin
        if (exp_b.size() == 0) chk(0, "R5", "unexpected byte command", {8'h0, b_data}, 0);
        else begin
          logic [31:0] e;
          e = exp_b.pop_front();
          chk({8'h0, b_data} == e, "R1", "byte command", {8'h0, b_data}, e);
          last_b = e;
        end
      end
      if (w_valid) begin
        if (exp_w.size() == 0) chk(0, "R5", "unexpected word command", w_data, 0);
        else begin
          logic [31:0] e;
          e = exp_w.pop_front();
          chk(w_data == e, "R2", "word command", w_data, e);
          last_w = e;
        end
      end
      if (prev_bv && b_valid) chk(0, "R9", "byte strobe longer than one cycle", 1, 0);
      if (prev_wv && w_valid) chk(0, "R9", "word strobe longer than one cycle", 1, 0);
      if (b_valid && b_to) chk(0, "R11", "byte valid with abort", 1, 0);
      if (w_valid && w_to) chk(0, "R11", "word valid with abort", 1, 0);
      prev_bv = b_valid;
      prev_wv = w_valid;
      if (b_to) seen_to_b++;
      if (w_to) seen_to_w++;
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ser_bit(input bit w, input bit s, input bit d);
    if (w) begin w_fs = s; w_dat = d; end else begin b_fs = s; b_dat = d; end
    wait_cyc(50);
    if (w) w_sclk = 1; else b_sclk = 1;
    wait_cyc(50);
    if (w) begin w_sclk = 0; w_fs = 0; end else begin b_sclk = 0; b_fs = 0; end
  endtask

  task automatic send_unit(input bit w, input logic [15:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) ser_bit(w, 1'b0, v[i]);
  endtask

  // sends k units of a command; gap cycles are inserted before the last one
  task automatic send_part(input bit w, input logic [31:0] d, input int k,
                           input int gap);
    int n, tot;
    n   = w ? 16 : 8;
    tot = w ? 2 : 3;
    for (int u = 0; u < k; u++) begin
      if (u == tot - 1) wait_cyc(gap);
      send_unit(w, 16'(d >> ((tot - 1 - u) * n)), n);
      if (u < k - 1) ser_bit(w, 1'b1, 1'b0);
    end
  endtask

  task automatic send_cmd(input bit w, input logic [31:0] d, input int gap);
    if (w) exp_w.push_back(d); else exp_b.push_back(d);
    send_part(w, d, w ? 2 : 3, gap);
    wait_cyc(20);
  endtask

  task automatic check_aborts(input string req);
    chk(seen_to_b == exp_to_b, req, "byte abort count", seen_to_b, exp_to_b);
    chk(seen_to_w == exp_to_w, req, "word abort count", seen_to_w, exp_to_w);
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    wait_cyc(10);
    // R10: outputs held at zero in reset
    chk(!b_valid && !b_to && b_data == 0, "R10", "byte reset outputs", {8'h0, b_data}, 0);
    chk(!w_valid && !w_to && w_data == 0, "R10", "word reset outputs", w_data, 0);
    rst_n = 1;
    wait_cyc(5);
    chk(!b_valid && !b_to && b_data == 0, "R10", "byte after reset", {8'h0, b_data}, 0);

    // R1, R3: byte commands with boundaries between units
    send_cmd(0, 32'h00A53C0F, 0);
    send_cmd(0, 32'h0000FF81, 0);
    // R2: word commands
    send_cmd(1, 32'hBEEF1234, 0);
    send_cmd(1, 32'h00018000, 0);
    check_aborts("R3");

    // R8: boundaries while idle are ignored
    ser_bit(0, 1'b1, 1'b0);
    ser_bit(0, 1'b1, 1'b1);
    ser_bit(1, 1'b1, 1'b0);
    wait_cyc(20);
    check_aborts("R8");
    send_cmd(0, 32'h00123456, 0);

    // R4: slow command still inside the 15 us window
    send_cmd(0, 32'h00C3E7FF, 300);
    check_aborts("R4");

    // R5: stall after the first unit
    send_part(0, 32'h00777777, 1, 0);
    wait_cyc(3200);
    exp_to_b++;
    check_aborts("R5");
    chk(b_data == last_b[23:0], "R9", "byte data held over abort", {8'h0, b_data}, last_b);
    send_cmd(0, 32'h00010203, 0);

    send_part(1, 32'h55550000, 1, 0);
    wait_cyc(3800);
    exp_to_w++;
    check_aborts("R5");
    chk(w_data == last_w, "R9", "word data held over abort", w_data, last_w);
    send_cmd(1, 32'hCAFE0F0F, 0);

    // R5: deadline passes in the gap before the third unit
    send_part(0, 32'h00999999, 2, 0);
    wait_cyc(1500);
    exp_to_b++;
    check_aborts("R5");
    send_cmd(0, 32'h00FEDCBA, 0);

    // R6: boundary in the middle of a unit
    send_unit(0, 16'h0015, 5);
    ser_bit(0, 1'b1, 1'b0);
    wait_cyc(10);
    exp_to_b++;
    check_aborts("R6");
    send_cmd(0, 32'h00808001, 0);

    // R7: missing boundary between units; leftover bits then time out
    send_unit(0, 16'h00AA, 8);
    send_unit(0, 16'h0055, 8);
    wait_cyc(10);
    exp_to_b++;
    check_aborts("R7");
    wait_cyc(3200);
    exp_to_b++;
    check_aborts("R7");
    send_cmd(0, 32'h003C3C3C, 0);

    wait_cyc(20);
    chk(exp_b.size() == 0, "R1", "byte commands outstanding", exp_b.size(), 0);
    chk(exp_w.size() == 0, "R2", "word commands outstanding", exp_w.size(), 0);
    check_aborts("R5");
    done = 1;
    finish_run();
  end
endmodule